// File: doc/BRIEF.md
# Debug Component ROM Table

This block is a read-only lookup table that sits on an APB slave port of a debug bus. A debugger walks it to find the debug components that share the bus. Each word in the low part of a 4KB window holds one component entry: a signed offset, counted in 4KB blocks, from the table's own base to the component, plus a present bit and a format bit. The list ends with a zero word. The top 64 bytes of the window hold fixed identification bytes that mark the window as a ROM table and carry the part number, revision and JEDEC manufacturer code. Every other location reads as zero.

The port has no write-data input. A write completes like any other transfer but changes nothing. Address bit 31 is not decoded, so the table answers at two aliased bases. The control logic is a two-state machine. ST_IDLE covers the cycles between transfers and the setup phase. The transition SETUP_SEEN (PSEL high and PENABLE low at a clock edge) moves it to ST_ACCESS, and at that same edge the read data is captured. The transition XFER_DONE returns it to ST_IDLE at the next edge. PREADY is high in ST_ACCESS.

Top module: `dbg_rom_table`

## Requirements
- R1: In the access phase that follows every setup phase, `pready` is 1 in that cycle (zero wait states), and `pslverr` is always 0.
- R2: `prdata` is captured at the clock edge that ends the setup phase and holds its value until the next setup phase. Reset (active-low, asynchronous) clears it to 0 and holds `pready` low.
- R3: Only address bits [11:2] are decoded. An access at 0x80000000 plus an offset returns the same data as an access at the offset alone.
- R4: Entry word k, for k below NUM_ENTRIES, at offset 4*k in the range 0x000–0xEFC, carries in bits [31:12] the signed 20-bit block offset given for component k. The component address is the table base plus that offset shifted left by 12.
- R5: Every present entry reads bit 0 = 1 (present) and bit 1 = 1 (32-bit format), with bits [11:2] = 0.
- R6: The word at index NUM_ENTRIES (the terminator) and every later word up to 0xEFC reads 0x00000000.
- R7: The identification words at 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0x10, 0x05 and 0xB1.
- R8: The peripheral ID words are laid out as follows.
  - 0xFE0 = part[7:0].
  - 0xFE4 = {jep[3:0], part[11:8]}.
  - 0xFE8 = {revision[3:0], jedec_used, jep[6:4]}.
  - 0xFEC = {rev_and[3:0], cust_mod[3:0]}.
  - 0xFD0 = {4'h0 block count, continuation[3:0]}.
  - 0xFD4, 0xFD8 and 0xFDC read 0.
- R9: Offsets 0xF00–0xFCC read 0, and bits [31:8] of every word in 0xFD0–0xFFC read 0.
- R10: A write transfer completes with `pready` high and `prdata` = 0, and it leaves every table word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | Transfer direction (1 = write, ignored) |
| paddr | input | 32 | Byte address; only bits [11:2] decoded |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Transfer complete, high in access phase |
| pslverr | output | 1 | Error response, always low |

## Verification
Reads are run over each region of the window in turn:
- Reads of the present entries, one of them with a negative offset, show that the offset sign and the low flag bits are built correctly.
- Reads of the terminator and of the last entry word show that the list stops where it should.
- Reads of the reserved gap and of the peripheral and component ID words tell the region boundaries apart.
- The same offsets read with bit 31 set show the aliasing.
- A write followed by a read of the same word separates "ignored" from "stored".
- An idle stretch after a read shows that the read data is held.

// File: rtl/dbg_rom_pkg.sv
package dbg_rom_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } bus_state_e;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned IDX_W       = 10;
    localparam int unsigned OFFS_W      = 20;
    localparam int unsigned ENTRY_LIMIT = 960;
    localparam logic [IDX_W-1:0] ID_FIRST = 10'h3F4;
endpackage

// File: rtl/rom_entry_lut.sv
module rom_entry_lut
    import dbg_rom_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*OFFS_W-1:0] ENTRY_OFFS = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] ent [NUM_ENTRIES];

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
        // block offset, reserved zeros, format = 32-bit, present
        assign ent[k] = {ENTRY_OFFS[k*OFFS_W +: OFFS_W], 10'b0, 2'b11};
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (idx == IDX_W'(k)) word = ent[k];
        end
    end
endmodule

// File: rtl/rom_id_regs.sv
module rom_id_regs #(
    parameter logic [11:0] PART_NUM   = 12'h000,
    parameter logic [6:0]  JEP_ID     = 7'h00,
    parameter logic [3:0]  JEP_CONT   = 4'h0,
    parameter logic        JEDEC_USED = 1'b0,
    parameter logic [3:0]  REVISION   = 4'h0,
    parameter logic [3:0]  REV_AND    = 4'h0,
    parameter logic [3:0]  CUST_MOD   = 4'h0
) (
    input  logic [3:0] sel,
    output logic [7:0] id_byte
);
    always_comb begin
        case (sel)
            4'h4:    id_byte = {4'h0, JEP_CONT};
            4'h8:    id_byte = PART_NUM[7:0];
            4'h9:    id_byte = {JEP_ID[3:0], PART_NUM[11:8]};
            4'hA:    id_byte = {REVISION, JEDEC_USED, JEP_ID[6:4]};
            4'hB:    id_byte = {REV_AND, CUST_MOD};
            4'hC:    id_byte = 8'h0D;
            4'hD:    id_byte = 8'h10;
            4'hE:    id_byte = 8'h05;
            4'hF:    id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/dbg_rom_table.sv
module dbg_rom_table
    import dbg_rom_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*OFFS_W-1:0] ENTRY_OFFS = {20'hFFFFF, 20'h00002, 20'h00001},
    parameter logic [11:0] PART_NUM   = 12'h4A7,
    parameter logic [6:0]  JEP_ID     = 7'h3B,
    parameter logic [3:0]  JEP_CONT   = 4'h4,
    parameter logic        JEDEC_USED = 1'b1,
    parameter logic [3:0]  REVISION   = 4'h2,
    parameter logic [3:0]  REV_AND    = 4'h0,
    parameter logic [3:0]  CUST_MOD   = 4'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [31:0] paddr,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr
);
    bus_state_e state_q, state_d;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] ent_word;
    logic [7:0]        id_byte;
    logic [WORD_W-1:0] lookup;
    logic              setup_seen;
    logic              unused_addr_bits;

    assign widx             = paddr[11:2];
    assign unused_addr_bits = ^{paddr[31:12], paddr[1:0]};
    assign setup_seen       = psel && !penable;

    rom_entry_lut #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .ENTRY_OFFS (ENTRY_OFFS)
    ) u_entries (
        .idx (widx),
        .word(ent_word)
    );

    rom_id_regs #(
        .PART_NUM  (PART_NUM),
        .JEP_ID    (JEP_ID),
        .JEP_CONT  (JEP_CONT),
        .JEDEC_USED(JEDEC_USED),
        .REVISION  (REVISION),
        .REV_AND   (REV_AND),
        .CUST_MOD  (CUST_MOD)
    ) u_ids (
        .sel    (widx[3:0]),
        .id_byte(id_byte)
    );

    always_comb begin
        if (widx < IDX_W'(ENTRY_LIMIT))  lookup = ent_word;
        else if (widx >= ID_FIRST)       lookup = {24'h0, id_byte};
        else                             lookup = '0;
    end

    // next-state: SETUP_SEEN -> ST_ACCESS, XFER_DONE -> ST_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = setup_seen ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          prdata <= '0;
        else if (setup_seen) prdata <= pwrite ? '0 : lookup;
    end

    assign pready  = (state_q == ST_ACCESS);
    assign pslverr = 1'b0;

    p_zero_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        setup_seen |=> pready);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |=> $stable(prdata));
    p_entry_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && !pwrite && widx < IDX_W'(NUM_ENTRIES))
        |=> (prdata[1:0] == 2'b11 && prdata[11:2] == 10'h0));
    p_terminator_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && !pwrite && widx >= IDX_W'(NUM_ENTRIES) && widx < IDX_W'(ENTRY_LIMIT))
        |=> (prdata == 32'h0));
    p_reserved_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && widx >= IDX_W'(ENTRY_LIMIT) && widx < ID_FIRST) |=> (prdata == 32'h0));
    p_id_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && widx >= ID_FIRST) |=> (prdata[31:8] == 24'h0));
    p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && pwrite) |=> (prdata == 32'h0 && pready));
endmodule

// File: tb/dbg_rom_table_tb.sv
module dbg_rom_table_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_rom_table #(
        .NUM_ENTRIES(3),
        .ENTRY_OFFS ({20'hFFFFF, 20'h00002, 20'h00001}),
        .PART_NUM   (12'h4A7),
        .JEP_ID     (7'h3B),
        .JEP_CONT   (4'h4),
        .JEDEC_USED (1'b1),
        .REVISION   (4'h2),
        .REV_AND    (4'h0),
        .CUST_MOD   (4'h0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // monitor: access phase sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && psel && penable) begin
            check("R1 pready", {31'h0, pready}, 32'h1);
            check("R1 pslverr", {31'h0, pslverr}, 32'h0);
            if (exp_q.size() == 0) check("scoreboard empty", 32'h1, 32'h0);
            else check(tag_q.pop_front(), prdata, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset prdata", prdata, 32'h0);
        check("R2 reset pready", {31'h0, pready}, 32'h0);
        rst_n = 1'b1;

        xfer(1'b0, 32'h0000_0000, 32'h0000_1003, "R4 entry0");
        xfer(1'b0, 32'h0000_0004, 32'h0000_2003, "R4 entry1");
        xfer(1'b0, 32'h0000_0008, 32'hFFFF_F003, "R5 entry2 negative");
        xfer(1'b0, 32'h0000_000C, 32'h0000_0000, "R6 terminator");
        xfer(1'b0, 32'h0000_0EFC, 32'h0000_0000, "R6 last entry word");
        xfer(1'b0, 32'h0000_0F00, 32'h0000_0000, "R9 gap start");
        xfer(1'b0, 32'h0000_0FCC, 32'h0000_0000, "R9 gap end");
        xfer(1'b0, 32'h0000_0FF0, 32'h0000_000D, "R7 cid0");
        xfer(1'b0, 32'h0000_0FF4, 32'h0000_0010, "R7 cid1");
        xfer(1'b0, 32'h0000_0FF8, 32'h0000_0005, "R7 cid2");
        xfer(1'b0, 32'h0000_0FFC, 32'h0000_00B1, "R7 cid3");
        xfer(1'b0, 32'h0000_0FE0, 32'h0000_00A7, "R8 pid0");
        xfer(1'b0, 32'h0000_0FE4, 32'h0000_00B4, "R8 pid1");
        xfer(1'b0, 32'h0000_0FE8, 32'h0000_002B, "R8 pid2");
        xfer(1'b0, 32'h0000_0FEC, 32'h0000_0000, "R8 pid3");
        xfer(1'b0, 32'h0000_0FD0, 32'h0000_0004, "R8 pid4");
        xfer(1'b0, 32'h0000_0FD4, 32'h0000_0000, "R8 pid5");
        xfer(1'b0, 32'h0000_0FDC, 32'h0000_0000, "R8 pid7");
        xfer(1'b0, 32'h8000_0004, 32'h0000_2003, "R3 alias entry1");
        xfer(1'b0, 32'h8000_0FF0, 32'h0000_000D, "R3 alias cid0");
        xfer(1'b0, 32'h8000_0008, 32'hFFFF_F003, "R3 alias entry2");

        // R2: data held through idle cycles
        xfer(1'b0, 32'h0000_0FFC, 32'h0000_00B1, "R2 load");
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 hold idle", prdata, 32'h0000_00B1);

        // R10: write completes, returns zero, changes nothing
        xfer(1'b1, 32'h0000_0000, 32'h0000_0000, "R10 write data");
        xfer(1'b0, 32'h0000_0000, 32'h0000_1003, "R10 read after write");
        xfer(1'b1, 32'h0000_0FF0, 32'h0000_0000, "R10 write id");
        xfer(1'b0, 32'h0000_0FF0, 32'h0000_000D, "R10 id after write");

        repeat (2) @(posedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule